// File: doc/BRIEF.md
# I2C Command Master

This block is a single-master I2C controller that a host steers one step at a time. Each host command asks for one bus operation: a START, a repeated START, transmission of one byte (an address or data), reception of one byte, one acknowledge bit after a received byte, or a STOP. When an operation finishes, the block raises a sticky interrupt flag. A busy indicator covers the time from command acceptance until that flag is raised. The block does not queue work. A byte written for transmission while another operation is still running is discarded and raises a write-collision flag.

SCL and SDA are open-drain. The block reports each line as a "pull low" request and reads the resolved line level back. The SCL timing comes from a half-period counter reloaded from a 7-bit host value, and a slave can stretch the clock by holding SCL low. A bus monitor watches both lines for START and STOP conditions, keeps a status bit for each, and from them derives whether the bus is free. Received bytes leave on a valid/ready port. `rx_valid` stays high with `rx_data` held until the host asserts `rx_ready` in the same cycle. While a byte is waiting, any new receive command is refused, which is the back-pressure rule. The transmit side is a plain write strobe with no back-pressure, because a write that is not accepted is reported as a collision rather than stalled.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, both pull outputs are low (lines released), `busy`, `irq`, `wcol`, `bcol`, `rx_valid`, `start_seen` and `stop_seen` are 0, and `bus_free` is 1.
- R2: A START accepted on a free bus first pulls SDA low while SCL is released, then pulls SCL low, each for one half period. It then sets `irq` and leaves SCL held low. The monitor sets `start_seen` and clears `stop_seen`.
- R3: A `tx_wr` accepted while idle sends `tx_data` MSB first on eight SCL pulses. The block releases SDA for a ninth pulse and stores the sampled SDA level in `ack_status` (0 = acknowledged, 1 = not acknowledged).
- R4: `cmd_rcv` shifts in eight bits MSB first, sampling SDA at the end of each SCL high phase. It then sets `rx_valid` with the byte on `rx_data`. Both hold until a cycle with `rx_ready` high, and `cmd_rcv` is ignored while `rx_valid` is 1.
- R5: `cmd_ack` drives one SCL pulse with SDA low when `ack_bit` = 0 and SDA released when `ack_bit` = 1.
- R6: A STOP pulls SDA low, releases SCL, and then releases SDA while SCL is high. Afterwards `stop_seen` = 1, `start_seen` = 0 and `bus_free` = 1. `bus_free` is 1 exactly when `stop_seen` is 1 or both status bits are 0.
- R7: Every SCL high and low phase lasts `baud_div` + 1 clock cycles when no slave stretches the clock.
- R8: While the block releases SCL but the line stays low, the half-period counter holds, so the operation neither advances nor completes.
- R9: A `tx_wr` that arrives while busy, or together with a START, repeated START or STOP command, is dropped and sets `wcol` until `wcol_clr`.
- R10: If SDA reads low when the block wants SDA high, `bcol` is set and the block returns to idle without setting `irq`. This covers a START, the end of a STOP, the release step of a repeated START, and a transmitted 1 bit.
- R11: `busy` rises in the cycle after a command is accepted and falls in the same cycle that `irq` rises. `irq` stays set until `irq_clr`.
- R12: With `enable` low, the block releases both lines, abandons any operation, and clears `start_seen` and `stop_seen`.
- R13: A repeated START from a held-low SCL releases SDA, then SCL, and then produces a new START condition on the bus before setting `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and clears bus status |
| baud_div | input | 7 | Half-period reload value (half period = value + 1 clocks) |
| cmd_start | input | 1 | Request a START (one-cycle strobe) |
| cmd_rstart | input | 1 | Request a repeated START |
| cmd_stop | input | 1 | Request a STOP |
| cmd_rcv | input | 1 | Request reception of one byte |
| cmd_ack | input | 1 | Request one acknowledge bit |
| ack_bit | input | 1 | Level for `cmd_ack`: 0 acknowledge, 1 not acknowledge |
| tx_wr | input | 1 | Write strobe starting transmission of `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Host takes the received byte |
| irq | output | 1 | Sticky operation-complete flag |
| irq_clr | input | 1 | Clears `irq` |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears `wcol` |
| bcol | output | 1 | Sticky bus-collision flag |
| bcol_clr | input | 1 | Clears `bcol` |
| busy | output | 1 | An operation is in progress |
| ack_status | output | 1 | Acknowledge level sampled after the last transmitted byte |
| start_seen | output | 1 | START observed on the bus since the last STOP |
| stop_seen | output | 1 | STOP observed on the bus since the last START |
| bus_free | output | 1 | Bus available to this master |
| scl_i | input | 1 | Resolved SCL line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Resolved SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that the line inputs are the wired-AND of this block's pulls and those of other devices. They also assume that a slave changes SDA only while SCL is low, except when it deliberately forces a collision, and that the host drains or ignores `rx_data` through the ready handshake. The bench models both lines as pull-up wires with a behavioural slave whose SDA and SCL pulls change only right after an SCL falling edge, or while SCL is held low for stretching. The exceptions are the one test that holds SDA low to provoke a START collision and the test of abandoning a START with `enable`. `baud_div` is kept at 1 or above and changed only while the block is idle. Command strobes last exactly one cycle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_A,
    ST_START_B,
    ST_RS_A,
    ST_RS_B,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_BIT_LO,
    ST_BIT_HI
  } eng_state_t;

  typedef enum logic [1:0] {
    XF_TX,
    XF_RX,
    XF_ACK
  } xfer_kind_t;
endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] reload,
  output logic             tick,
  output logic [DIV_W-1:0] cnt
);
  localparam logic [DIV_W-1:0] ZERO = '0;

  assign tick = run && !hold && (cnt == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
    end else if (!run) begin
      cnt <= reload;
    end else if (!hold) begin
      if (cnt == ZERO) cnt <= reload;
      else             cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free
);
  logic scl_q, sda_q;
  logic start_det, stop_det;

  assign start_det = scl_i && scl_q && sda_q && !sda_i;
  assign stop_det  = scl_i && scl_q && !sda_q && sda_i;
  assign bus_free  = stop_seen || (!start_seen && !stop_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (!enable) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b0;
      end else if (start_det) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
      end else if (stop_det) begin
        start_seen <= 1'b0;
        stop_seen  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              bus_free,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              ack_bit,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_ready,
  input  logic              irq_clr,
  input  logic              wcol_clr,
  input  logic              bcol_clr,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              busy,
  output logic              irq,
  output logic              wcol,
  output logic              bcol,
  output logic              ack_status,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] ACK_SLOT  = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] FIRST     = '0;

  eng_state_t         state;
  xfer_kind_t         xf;
  logic [DATA_W-1:0]  sr;
  logic [BIT_W-1:0]   bitn;
  logic               ack_q;

  logic idle, go, other_cmd;
  logic acc_start, acc_rstart, acc_stop, acc_tx, acc_rx, acc_ack;
  logic start_blocked, wcol_hit;
  logic bit_drive, last_bit, one_lost;

  assign idle      = (state == ST_IDLE);
  assign busy      = !idle;
  assign go        = enable && idle;
  assign other_cmd = cmd_start || cmd_rstart || cmd_stop;

  assign acc_start  = go && cmd_start;
  assign acc_rstart = go && !cmd_start && cmd_rstart;
  assign acc_stop   = go && !cmd_start && !cmd_rstart && cmd_stop;
  assign acc_tx     = go && !other_cmd && tx_wr;
  assign acc_rx     = go && !other_cmd && !tx_wr && cmd_rcv && !rx_valid;
  assign acc_ack    = go && !other_cmd && !tx_wr && !cmd_rcv && cmd_ack;

  assign start_blocked = !bus_free || !sda_i || !scl_i;
  assign wcol_hit      = enable && tx_wr && (!idle || other_cmd);

  always_comb begin
    bit_drive = 1'b0;
    last_bit  = 1'b0;
    one_lost  = 1'b0;
    unique case (xf)
      XF_TX: begin
        bit_drive = (bitn == ACK_SLOT) ? 1'b0 : !sr[DATA_W-1];
        last_bit  = (bitn == ACK_SLOT);
        one_lost  = (bitn != ACK_SLOT) && sr[DATA_W-1] && !sda_i;
      end
      XF_RX: begin
        bit_drive = 1'b0;
        last_bit  = (bitn == LAST_DATA);
      end
      default: begin
        bit_drive = !ack_q;
        last_bit  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      xf         <= XF_TX;
      sr         <= '0;
      bitn       <= FIRST;
      ack_q      <= 1'b0;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
      irq        <= 1'b0;
      wcol       <= 1'b0;
      bcol       <= 1'b0;
      ack_status <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
    end else begin
      if (irq_clr)              irq      <= 1'b0;
      if (wcol_clr)             wcol     <= 1'b0;
      if (bcol_clr)             bcol     <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (wcol_hit)             wcol     <= 1'b1;

      if (!enable) begin
        state    <= ST_IDLE;
        scl_pull <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (acc_start) begin
              if (start_blocked) begin
                bcol <= 1'b1;
              end else begin
                state    <= ST_START_A;
                sda_pull <= 1'b1;
              end
            end else if (acc_rstart) begin
              state    <= ST_RS_A;
              sda_pull <= 1'b0;
              scl_pull <= 1'b1;
            end else if (acc_stop) begin
              state    <= ST_STOP_A;
              sda_pull <= 1'b1;
              scl_pull <= 1'b1;
            end else if (acc_tx || acc_rx || acc_ack) begin
              state    <= ST_BIT_LO;
              scl_pull <= 1'b1;
              bitn     <= FIRST;
              if (acc_tx) begin
                xf <= XF_TX;
                sr <= tx_data;
              end else if (acc_rx) begin
                xf <= XF_RX;
              end else begin
                xf    <= XF_ACK;
                ack_q <= ack_bit;
              end
            end
          end
          ST_START_A: if (tick) begin
            state    <= ST_START_B;
            scl_pull <= 1'b1;
          end
          ST_START_B: if (tick) begin
            state <= ST_IDLE;
            irq   <= 1'b1;
          end
          ST_RS_A: if (tick) begin
            state    <= ST_RS_B;
            scl_pull <= 1'b0;
          end
          ST_RS_B: if (tick) begin
            if (!sda_i) begin
              state <= ST_IDLE;
              bcol  <= 1'b1;
            end else begin
              state    <= ST_START_A;
              sda_pull <= 1'b1;
            end
          end
          ST_STOP_A: if (tick) begin
            state    <= ST_STOP_B;
            scl_pull <= 1'b0;
          end
          ST_STOP_B: if (tick) begin
            state    <= ST_STOP_C;
            sda_pull <= 1'b0;
          end
          ST_STOP_C: if (tick) begin
            state <= ST_IDLE;
            if (!sda_i) bcol <= 1'b1;
            else        irq  <= 1'b1;
          end
          ST_BIT_LO: begin
            sda_pull <= bit_drive;
            if (tick) begin
              state    <= ST_BIT_HI;
              scl_pull <= 1'b0;
            end
          end
          ST_BIT_HI: if (tick) begin
            if (one_lost) begin
              state    <= ST_IDLE;
              bcol     <= 1'b1;
              sda_pull <= 1'b0;
            end else if (last_bit) begin
              state    <= ST_IDLE;
              scl_pull <= 1'b1;
              irq      <= 1'b1;
              if (xf == XF_TX) ack_status <= sda_i;
              if (xf == XF_RX) begin
                rx_data  <= {sr[DATA_W-2:0], sda_i};
                rx_valid <= 1'b1;
              end
            end else begin
              state    <= ST_BIT_LO;
              scl_pull <= 1'b1;
              bitn     <= bitn + 1'b1;
              if (xf == XF_TX) sr <= {sr[DATA_W-2:0], 1'b0};
              else             sr <= {sr[DATA_W-2:0], sda_i};
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  logic unused_scl;
  assign unused_scl = scl_i;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DIV_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              ack_bit,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              irq,
  input  logic              irq_clr,
  output logic              wcol,
  input  logic              wcol_clr,
  output logic              bcol,
  input  logic              bcol_clr,
  output logic              busy,
  output logic              ack_status,
  output logic              start_seen,
  output logic              stop_seen,
  output logic              bus_free,
  input  logic              scl_i,
  output logic              scl_pull,
  input  logic              sda_i,
  output logic              sda_pull
);
  logic             tick;
  logic             hold;
  logic [DIV_W-1:0] baud_cnt;

  assign hold = !scl_pull && !scl_i;

  i2cm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .hold   (hold),
    .reload (baud_div),
    .tick   (tick),
    .cnt    (baud_cnt)
  );

  i2cm_busmon u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .bus_free   (bus_free)
  );

  i2cm_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (tick),
    .bus_free   (bus_free),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .cmd_start  (cmd_start),
    .cmd_rstart (cmd_rstart),
    .cmd_stop   (cmd_stop),
    .cmd_rcv    (cmd_rcv),
    .cmd_ack    (cmd_ack),
    .ack_bit    (ack_bit),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .rx_ready   (rx_ready),
    .irq_clr    (irq_clr),
    .wcol_clr   (wcol_clr),
    .bcol_clr   (bcol_clr),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .busy       (busy),
    .irq        (irq),
    .wcol       (wcol),
    .bcol       (bcol),
    .ack_status (ack_status),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int DIV_W  = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              tx_wr,
  input logic              busy,
  input logic              irq,
  input logic              wcol,
  input logic              bcol,
  input logic              start_seen,
  input logic              stop_seen,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              scl_pull,
  input logic              scl_i,
  input logic [DIV_W-1:0]  baud_cnt
);
  assert_wcol_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_wr && busy) |=> wcol);

  assert_busy_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq || bcol || !$past(enable)));

  assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);

  assert_bcol_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol) |-> !busy);

  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen && !busy));

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && !scl_pull && !scl_i) |=> $stable(baud_cnt));
endmodule

bind i2c_cmd_master i2cm_checker #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .tx_wr      (tx_wr),
  .busy       (busy),
  .irq        (irq),
  .wcol       (wcol),
  .bcol       (bcol),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .scl_pull   (scl_pull),
  .scl_i      (scl_i),
  .baud_cnt   (baud_cnt)
);

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       enable = 1'b1;
  logic [6:0] baud_div = 7'd3;
  logic cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0, ack_bit = 0;
  logic tx_wr = 0;
  logic [7:0] tx_data = 8'h00;
  logic rx_ready = 0, irq_clr = 0, wcol_clr = 0, bcol_clr = 0;
  logic [7:0] rx_data;
  logic rx_valid, irq, wcol, bcol, busy, ack_status, start_seen, stop_seen, bus_free;
  logic scl_pull, sda_pull;
  logic s_scl = 1'b0, s_sda = 1'b0;
  wire  scl_line = !(scl_pull || s_scl);
  wire  sda_line = !(sda_pull || s_sda);

  i2c_cmd_master dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .baud_div(baud_div),
    .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
    .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_bit(ack_bit),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .irq(irq), .irq_clr(irq_clr), .wcol(wcol),
    .wcol_clr(wcol_clr), .bcol(bcol), .bcol_clr(bcol_clr), .busy(busy),
    .ack_status(ack_status), .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free), .scl_i(scl_line), .scl_pull(scl_pull),
    .sda_i(sda_line), .sda_pull(sda_pull)
  );

  int checks = 0;
  int errors = 0;
  int n_starts = 0;
  int hi_run = 0;
  int last_hi = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) n_starts++;

  always @(posedge clk) begin
    if (scl_line) hi_run <= hi_run + 1;
    else begin
      if (hi_run != 0) last_hi <= hi_run;
      hi_run <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cmd bits: {start, rstart, stop, tx, rcv, ack}
  task automatic issue(input logic [5:0] c, input logic [7:0] d, input logic a);
    @(negedge clk);
    {cmd_start, cmd_rstart, cmd_stop, tx_wr, cmd_rcv, cmd_ack} = c;
    tx_data = d;
    ack_bit = a;
    @(negedge clk);
    {cmd_start, cmd_rstart, cmd_stop, tx_wr, cmd_rcv, cmd_ack} = 6'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(req, irq, 1'b1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic slave_rx(output logic [7:0] got, input logic give_ack);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      got = {got[6:0], sda_line};
    end
    @(negedge scl_line);
    s_sda = give_ack;
    @(negedge scl_line);
    s_sda = 1'b0;
  endtask

  task automatic slave_tx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      s_sda = !b[i];
      @(posedge scl_line);
      @(negedge scl_line);
    end
    s_sda = 1'b0;
  endtask

  // {byte[15:8], slave_nack[7], baud_div[6:0]}
  localparam logic [15:0] VEC [6] = '{16'hA503, 16'h3C81, 16'hFF06,
                                       16'h0082, 16'h8004, 16'h0185};

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       v;
    int         st0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl", scl_line, 1'b1);
    chk("R1 sda", sda_line, 1'b1);
    chk("R1 flags", {busy, irq, wcol, bcol, rx_valid}, 5'b0);
    chk("R1 status", {start_seen, stop_seen, bus_free}, 3'b001);

    for (int k = 0; k < 6; k++) begin
      baud_div = VEC[k][6:0];
      issue(6'b100000, 8'h00, 1'b0);
      chk("R11 busy after accept", busy, 1'b1);
      wait_irq("R2 start irq");
      chk("R2 start_seen", {start_seen, stop_seen, scl_line}, 3'b100);
      fork
        slave_rx(got, !VEC[k][7]);
        begin
          issue(6'b000100, VEC[k][15:8], 1'b0);
          wait_irq("R3 tx irq");
        end
      join
      chk("R3 byte on bus", got, VEC[k][15:8]);
      chk("R3 ack_status", ack_status, VEC[k][7]);
      chk("R7 scl high width", last_hi, 32'(VEC[k][6:0]) + 1);
      issue(6'b001000, 8'h00, 1'b0);
      wait_irq("R6 stop irq");
      chk("R6 status after stop", {start_seen, stop_seen, bus_free, sda_line, scl_line}, 5'b01111);
    end
    baud_div = 7'd3;

    // receive, back-pressure, acknowledge, repeated start
    issue(6'b100000, 8'h00, 1'b0);
    wait_irq("R2 start irq");
    fork
      slave_tx(8'h96);
      begin
        issue(6'b000010, 8'h00, 1'b0);
        wait_irq("R4 rx irq");
      end
    join
    chk("R4 rx_valid", rx_valid, 1'b1);
    chk("R4 rx_data", rx_data, 8'h96);
    issue(6'b000010, 8'h00, 1'b0);
    chk("R4 rcv ignored while valid", {busy, rx_valid, rx_data}, {2'b01, 8'h96});
    fork
      issue(6'b000001, 8'h00, 1'b0);
      begin @(posedge scl_line); v = sda_line; end
    join
    wait_irq("R5 ack irq");
    chk("R5 ack low", v, 1'b0);
    @(negedge clk); rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    chk("R4 ready drains", rx_valid, 1'b0);
    fork
      slave_tx(8'h5B);
      begin
        issue(6'b000010, 8'h00, 1'b0);
        wait_irq("R4 rx irq");
      end
    join
    chk("R4 rx_data second", rx_data, 8'h5B);
    fork
      issue(6'b000001, 8'h00, 1'b1);
      begin @(posedge scl_line); v = sda_line; end
    join
    wait_irq("R5 nack irq");
    chk("R5 nack released", v, 1'b1);
    @(negedge clk); rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    st0 = n_starts;
    issue(6'b010000, 8'h00, 1'b0);
    wait_irq("R13 rstart irq");
    chk("R13 new start on bus", n_starts - st0, 1);
    chk("R13 status", {start_seen, stop_seen, scl_line}, 3'b100);
    issue(6'b001000, 8'h00, 1'b0);
    wait_irq("R6 stop irq");

    // R8 clock stretching
    issue(6'b100000, 8'h00, 1'b0);
    wait_irq("R2 start irq");
    s_scl = 1'b1;
    fork
      slave_rx(got, 1'b1);
      begin
        issue(6'b000100, 8'hC3, 1'b0);
        repeat (300) @(negedge clk);
        chk("R8 held while stretched", {busy, irq, scl_line}, 3'b100);
        s_scl = 1'b0;
        wait_irq("R8 tx irq after stretch");
      end
    join
    chk("R8 byte after stretch", got, 8'hC3);
    issue(6'b001000, 8'h00, 1'b0);
    wait_irq("R6 stop irq");

    // R9 write collision
    issue(6'b100000, 8'h00, 1'b0);
    issue(6'b000100, 8'hAA, 1'b0);
    wait_irq("R9 start irq");
    chk("R9 wcol set", wcol, 1'b1);
    repeat (40) @(negedge clk);
    chk("R9 write dropped", {busy, irq, scl_line}, 3'b000);
    @(negedge clk); wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
    chk("R9 wcol cleared", wcol, 1'b0);
    issue(6'b001000, 8'h00, 1'b0);
    wait_irq("R6 stop irq");

    // R10 bus collision on START
    s_sda = 1'b1;
    repeat (2) @(negedge clk);
    issue(6'b100000, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    chk("R10 bcol on start", {bcol, busy, irq, scl_pull}, 4'b1000);
    s_sda = 1'b0;
    @(negedge clk); bcol_clr = 1'b1; @(negedge clk); bcol_clr = 1'b0;
    chk("R10 bcol cleared", bcol, 1'b0);

    // R12 disable
    issue(6'b100000, 8'h00, 1'b0);
    wait_irq("R2 start irq");
    chk("R12 start_seen before", start_seen, 1'b1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 disabled", {start_seen, stop_seen, busy, scl_line, sda_line}, 5'b00011);
    enable = 1'b1;
    issue(6'b100000, 8'h00, 1'b0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 abort start", {busy, irq, scl_line, sda_line}, 4'b0011);
    enable = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule